// File: doc/BRIEF.md
# Hysteretic Digital AGC Gain Controller

This block closes a digital automatic gain control loop around a stepped variable-gain amplifier. It accepts a stream of sample magnitudes and returns a gain word. One unit of the gain word is one nominal 0.094 dB amplifier step, and a larger word means more gain. The samples are grouped into measurement windows of a programmable number of accepted samples. The largest magnitude seen in a window is compared against an upper and a lower threshold. Inside that band the gain is left alone. Above the band a slow proportional loop lowers the gain, and below it the loop raises the gain. In both cases the loop pulls the peak toward a requested target, scaled by a mantissa/exponent loop gain.

Two faster paths run alongside the slow loop. When fast attack is enabled, the gain is cut by a programmed step as soon as enough samples within the current window exceed an overload threshold. When fast decay is enabled, a window that ends below the band raises the gain by at least a programmed step. A force control bypasses all of this and holds the gain at a programmed value. The sample input is a valid/ready stream. Ready is held high at all times, so an upstream source never sees back-pressure, and any cycle with valid low is simply not a sample. The configuration inputs are plain levels and are sampled on every clock.

Top module: `agc_gain_ctrl`

## Requirements
- R1: After reset the gain output equals the parameter GAIN_INIT.
- R2: A window ends on every (cfg_period + 1)-th accepted sample (s_valid high). Cycles with s_valid low do not count, do not feed the peak, and s_ready is always 1.
- R3: When a window ends and its peak (the largest magnitude in the window, including the last sample) satisfies cfg_lo_thr <= peak <= cfg_hi_thr, the gain does not change.
- R4: When a window ends with peak > cfg_hi_thr, the gain decreases by ((peak - cfg_target, or 0 if negative) * cfg_mant) >> (8 + cfg_exp). The loop gain is therefore mantissa/256 times 2^-exponent, with the mantissa in the range 0..63.
- R5: When a window ends with peak < cfg_lo_thr and peak <= cfg_hi_thr, the gain increases by ((cfg_target - peak, or 0 if negative) * cfg_mant) >> (8 + cfg_exp).
- R6: With cfg_fd_en = 1, a window that ends below the band raises the gain by the larger of the R5 step and cfg_fd_step.
- R7: With cfg_fa_en = 1 and cfg_fa_cnt nonzero, the accepted sample whose magnitude is strictly above cfg_fa_thr and brings the window's count of such samples to cfg_fa_cnt lowers the gain by cfg_fa_step at that same clock edge. The slow and fast-decay update of that window is then skipped. With cfg_fa_en = 0 this path has no effect.
- R8: The gain saturates at 0 and at 2^GAIN_W - 1 and never wraps.
- R9: While cfg_force = 1, the gain follows cfg_force_gain one clock later, and the window state is cleared. After release, the loop starts a fresh window from the forced value.
- R10: The gain changes only at a clock edge where a sample is accepted or cfg_force is high. Every change is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample magnitude valid |
| s_ready | output | 1 | Always 1; the block never stalls |
| s_mag | input | MAG_W | Sample magnitude |
| cfg_period | input | 8 | Window length minus one, in accepted samples |
| cfg_hi_thr | input | MAG_W | Upper hysteresis threshold |
| cfg_lo_thr | input | MAG_W | Lower hysteresis threshold |
| cfg_target | input | MAG_W | Requested peak level |
| cfg_mant | input | 6 | Slow loop gain mantissa (/256) |
| cfg_exp | input | 4 | Slow loop gain exponent (2^-exp) |
| cfg_fa_en | input | 1 | Fast attack enable |
| cfg_fa_thr | input | MAG_W | Fast attack overload threshold |
| cfg_fa_cnt | input | 8 | Overload samples per window that trigger fast attack |
| cfg_fa_step | input | 4 | Fast attack gain decrement |
| cfg_fd_en | input | 1 | Fast decay enable |
| cfg_fd_step | input | 4 | Fast decay minimum gain increment |
| cfg_force | input | 1 | Override the loop with cfg_force_gain |
| cfg_force_gain | input | GAIN_W | Forced gain word |
| gain | output | GAIN_W | Gain word to the amplifier |

## Verification
The bench builds the block with MAG_W = 12, GAIN_W = 6 and GAIN_INIT = 32. The narrow 6-bit gain word makes both saturation limits reachable within a few short windows, while 12-bit magnitudes with a mantissa up to 63 can still produce steps far larger than the whole gain range. The R8 clamps are therefore exercised from both sides. Short windows of one to four samples let fast attack fire on the last sample of a window as well as in its middle, and random valid gaps cover the R2 counting.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int PER_W     = 8;
  localparam int MANT_W    = 6;
  localparam int EXP_W     = 4;
  localparam int FCNT_W    = 8;
  localparam int FSTEP_W   = 4;
  localparam int LOOP_FRAC = 8;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_RAISE,
    ACT_LOWER,
    ACT_ATTACK,
    ACT_FORCE
  } gain_act_e;
endpackage

// File: rtl/agc_peak_meter.sv
module agc_peak_meter #(
  parameter int MAG_W = 12,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic [MAG_W-1:0] mag,
  input  logic [PER_W-1:0] period,
  output logic             last,
  output logic [MAG_W-1:0] peak
);
  logic [PER_W-1:0] cnt_q;
  logic [MAG_W-1:0] peak_q;

  assign last = accept && (cnt_q == period);
  assign peak = (mag > peak_q) ? mag : peak_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      peak_q <= '0;
    end else if (clr) begin
      cnt_q  <= '0;
      peak_q <= '0;
    end else if (accept) begin
      if (last) begin
        cnt_q  <= '0;
        peak_q <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        peak_q <= peak;
      end
    end
  end
endmodule

// File: rtl/agc_attack_det.sv
module agc_attack_det #(
  parameter int MAG_W = 12,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic             period_end,
  input  logic [MAG_W-1:0] mag,
  input  logic             en,
  input  logic [MAG_W-1:0] thresh,
  input  logic [CNT_W-1:0] count_lim,
  output logic             fire,
  output logic             fired_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             over;
  logic             inc;

  assign over = accept && (mag > thresh);
  assign inc  = over && (cnt_q != {CNT_W{1'b1}});
  assign fire = en && inc && (count_lim != '0) &&
                ((cnt_q + CNT_W'(1)) == count_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (accept) begin
      if (period_end) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else begin
        if (inc) cnt_q <= cnt_q + CNT_W'(1);
        fired_q <= fired_q | fire;
      end
    end
  end
endmodule

// File: rtl/agc_step_calc.sv
module agc_step_calc #(
  parameter int MAG_W   = 12,
  parameter int MANT_W  = 6,
  parameter int EXP_W   = 4,
  parameter int FSTEP_W = 4,
  parameter int FRAC    = 8,
  localparam int STEP_W = MAG_W + MANT_W
) (
  input  logic [MAG_W-1:0]   peak,
  input  logic [MAG_W-1:0]   hi_thr,
  input  logic [MAG_W-1:0]   lo_thr,
  input  logic [MAG_W-1:0]   target,
  input  logic [MANT_W-1:0]  mant,
  input  logic [EXP_W-1:0]   expo,
  input  logic               fd_en,
  input  logic [FSTEP_W-1:0] fd_step,
  output logic               go_dn,
  output logic               go_up,
  output logic [STEP_W-1:0]  step
);
  logic [MAG_W-1:0]  err_dn;
  logic [MAG_W-1:0]  err_up;
  logic [MAG_W-1:0]  err;
  logic [STEP_W-1:0] prod;
  logic [STEP_W-1:0] slow;

  assign go_dn  = peak > hi_thr;
  assign go_up  = !go_dn && (peak < lo_thr);
  assign err_dn = (peak > target) ? (peak - target) : '0;
  assign err_up = (target > peak) ? (target - peak) : '0;
  assign err    = go_up ? err_up : err_dn;
  assign prod   = STEP_W'(err) * STEP_W'(mant);
  assign slow   = prod >> (FRAC + int'(expo));

  always_comb begin
    step = slow;
    if (go_up && fd_en && (STEP_W'(fd_step) > slow)) step = STEP_W'(fd_step);
  end
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl #(
  parameter int MAG_W     = 12,
  parameter int GAIN_W    = 8,
  parameter int GAIN_INIT = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic [MAG_W-1:0]            s_mag,
  input  logic [agc_pkg::PER_W-1:0]   cfg_period,
  input  logic [MAG_W-1:0]            cfg_hi_thr,
  input  logic [MAG_W-1:0]            cfg_lo_thr,
  input  logic [MAG_W-1:0]            cfg_target,
  input  logic [agc_pkg::MANT_W-1:0]  cfg_mant,
  input  logic [agc_pkg::EXP_W-1:0]   cfg_exp,
  input  logic                        cfg_fa_en,
  input  logic [MAG_W-1:0]            cfg_fa_thr,
  input  logic [agc_pkg::FCNT_W-1:0]  cfg_fa_cnt,
  input  logic [agc_pkg::FSTEP_W-1:0] cfg_fa_step,
  input  logic                        cfg_fd_en,
  input  logic [agc_pkg::FSTEP_W-1:0] cfg_fd_step,
  input  logic                        cfg_force,
  input  logic [GAIN_W-1:0]           cfg_force_gain,
  output logic [GAIN_W-1:0]           gain
);
  import agc_pkg::*;

  localparam int STEP_W = MAG_W + MANT_W;
  localparam int WIDE   = (STEP_W > GAIN_W) ? STEP_W : GAIN_W;
  localparam int SUM_W  = WIDE + 2;
  localparam logic [SUM_W-1:0] GAIN_MAX = SUM_W'((64'd1 << GAIN_W) - 64'd1);

  logic               accept;
  logic               per_last;
  logic [MAG_W-1:0]   peak_val;
  logic               fa_fire;
  logic               fa_fired;
  logic               go_dn;
  logic               go_up;
  logic [STEP_W-1:0]  step;
  logic [GAIN_W-1:0]  gain_q;
  gain_act_e          act;

  assign s_ready = 1'b1;
  assign accept  = s_valid && !cfg_force;
  assign gain    = gain_q;

  agc_peak_meter #(.MAG_W(MAG_W), .PER_W(PER_W)) u_peak (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_force),
    .accept (accept),
    .mag    (s_mag),
    .period (cfg_period),
    .last   (per_last),
    .peak   (peak_val)
  );

  agc_attack_det #(.MAG_W(MAG_W), .CNT_W(FCNT_W)) u_attack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cfg_force),
    .accept     (accept),
    .period_end (per_last),
    .mag        (s_mag),
    .en         (cfg_fa_en),
    .thresh     (cfg_fa_thr),
    .count_lim  (cfg_fa_cnt),
    .fire       (fa_fire),
    .fired_q    (fa_fired)
  );

  agc_step_calc #(
    .MAG_W(MAG_W), .MANT_W(MANT_W), .EXP_W(EXP_W),
    .FSTEP_W(FSTEP_W), .FRAC(LOOP_FRAC)
  ) u_step (
    .peak    (peak_val),
    .hi_thr  (cfg_hi_thr),
    .lo_thr  (cfg_lo_thr),
    .target  (cfg_target),
    .mant    (cfg_mant),
    .expo    (cfg_exp),
    .fd_en   (cfg_fd_en),
    .fd_step (cfg_fd_step),
    .go_dn   (go_dn),
    .go_up   (go_up),
    .step    (step)
  );

  function automatic logic [GAIN_W-1:0] sat_add(input logic [GAIN_W-1:0] g,
                                                input logic [SUM_W-1:0] d);
    logic [SUM_W-1:0] s;
    s = SUM_W'(g) + d;
    return (s > GAIN_MAX) ? GAIN_MAX[GAIN_W-1:0] : s[GAIN_W-1:0];
  endfunction

  function automatic logic [GAIN_W-1:0] sat_sub(input logic [GAIN_W-1:0] g,
                                                input logic [SUM_W-1:0] d);
    logic [SUM_W-1:0] s;
    s = SUM_W'(g) - d;
    return (d >= SUM_W'(g)) ? '0 : s[GAIN_W-1:0];
  endfunction

  always_comb begin
    act = ACT_HOLD;
    if (cfg_force) act = ACT_FORCE;
    else if (fa_fire) act = ACT_ATTACK;
    else if (per_last && !fa_fired) begin
      if (go_dn) act = ACT_LOWER;
      else if (go_up) act = ACT_RAISE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_W'(GAIN_INIT);
    end else begin
      unique case (act)
        ACT_FORCE:  gain_q <= cfg_force_gain;
        ACT_ATTACK: gain_q <= sat_sub(gain_q, SUM_W'(cfg_fa_step));
        ACT_LOWER:  gain_q <= sat_sub(gain_q, SUM_W'(step));
        ACT_RAISE:  gain_q <= sat_add(gain_q, SUM_W'(step));
        default:    gain_q <= gain_q;
      endcase
    end
  end
endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk #(
  parameter int MAG_W  = 12,
  parameter int GAIN_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              cfg_force,
  input logic [GAIN_W-1:0] cfg_force_gain,
  input logic [MAG_W-1:0]  cfg_hi_thr,
  input logic [MAG_W-1:0]  cfg_lo_thr,
  input logic [GAIN_W-1:0] gain,
  input logic              per_last,
  input logic [MAG_W-1:0]  peak_val,
  input logic              fa_fire,
  input logic              fa_fired
);
  a_r9_force_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force |=> gain == $past(cfg_force_gain));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_force && !s_valid) |=> $stable(gain));

  a_r3_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_force && per_last && !fa_fire && !fa_fired &&
     peak_val <= cfg_hi_thr && peak_val >= cfg_lo_thr) |=> $stable(gain));

  a_r7_attack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_force && fa_fire) |=> gain <= $past(gain));

  a_r4_lower_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_force && per_last && !fa_fire && !fa_fired && peak_val > cfg_hi_thr)
    |=> gain <= $past(gain));

  a_r8_raise_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_force && per_last && !fa_fire && !fa_fired &&
     peak_val <= cfg_hi_thr && peak_val < cfg_lo_thr) |=> gain >= $past(gain));
endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(.MAG_W(MAG_W), .GAIN_W(GAIN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .s_valid        (s_valid),
  .cfg_force      (cfg_force),
  .cfg_force_gain (cfg_force_gain),
  .cfg_hi_thr     (cfg_hi_thr),
  .cfg_lo_thr     (cfg_lo_thr),
  .gain           (gain),
  .per_last       (per_last),
  .peak_val       (peak_val),
  .fa_fire        (fa_fire),
  .fa_fired       (fa_fired)
);

// File: tb/agc_gain_ctrl_bench.sv
module agc_gain_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAG_W      = 12;
  localparam int GAIN_W     = 6;
  localparam int GAIN_INIT  = 32;
  localparam int GMAX       = (1 << GAIN_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [MAG_W-1:0]  s_mag = '0;
  logic [7:0]        cfg_period = 8'd3;
  logic [MAG_W-1:0]  cfg_hi_thr = 12'd2000;
  logic [MAG_W-1:0]  cfg_lo_thr = 12'd1000;
  logic [MAG_W-1:0]  cfg_target = 12'd1500;
  logic [5:0]        cfg_mant = 6'd63;
  logic [3:0]        cfg_exp = 4'd4;
  logic              cfg_fa_en = 1'b0;
  logic [MAG_W-1:0]  cfg_fa_thr = 12'd3500;
  logic [7:0]        cfg_fa_cnt = 8'd2;
  logic [3:0]        cfg_fa_step = 4'd5;
  logic              cfg_fd_en = 1'b0;
  logic [3:0]        cfg_fd_step = 4'd9;
  logic              cfg_force = 1'b0;
  logic [GAIN_W-1:0] cfg_force_gain = '0;
  logic [GAIN_W-1:0] gain;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  int m_gain, m_cnt, m_peak, m_facnt, m_fired;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_gain_ctrl #(.MAG_W(MAG_W), .GAIN_W(GAIN_W), .GAIN_INIT(GAIN_INIT)) u_agc_gain_ctrl (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_mag(s_mag),
    .cfg_period(cfg_period), .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
    .cfg_target(cfg_target), .cfg_mant(cfg_mant), .cfg_exp(cfg_exp),
    .cfg_fa_en(cfg_fa_en), .cfg_fa_thr(cfg_fa_thr), .cfg_fa_cnt(cfg_fa_cnt),
    .cfg_fa_step(cfg_fa_step), .cfg_fd_en(cfg_fd_en), .cfg_fd_step(cfg_fd_step),
    .cfg_force(cfg_force), .cfg_force_gain(cfg_force_gain), .gain(gain)
  );

  task automatic check(input string t, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", t, got, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_peak = 0; m_facnt = 0; m_fired = 0;
  endtask

  // Behavioural reference for one clock edge, built from R2..R10.
  task automatic model_edge();
    int pk, st, err;
    bit last, inc, fire;
    if (cfg_force) begin
      m_gain = int'(cfg_force_gain);
      model_clear();
    end else if (s_valid) begin
      pk   = (int'(s_mag) > m_peak) ? int'(s_mag) : m_peak;
      last = (m_cnt == int'(cfg_period));
      inc  = (int'(s_mag) > int'(cfg_fa_thr)) && (m_facnt < 255);
      fire = cfg_fa_en && inc && (cfg_fa_cnt != 0) && (m_facnt + 1 == int'(cfg_fa_cnt));
      if (inc) m_facnt++;
      if (fire) begin
        m_gain = m_gain - int'(cfg_fa_step);
        if (m_gain < 0) m_gain = 0;
      end else if (last && m_fired == 0) begin
        if (pk > int'(cfg_hi_thr)) begin
          err = (pk > int'(cfg_target)) ? pk - int'(cfg_target) : 0;
          st = (err * int'(cfg_mant)) >> (8 + int'(cfg_exp));
          m_gain = m_gain - st;
          if (m_gain < 0) m_gain = 0;
        end else if (pk < int'(cfg_lo_thr)) begin
          err = (int'(cfg_target) > pk) ? int'(cfg_target) - pk : 0;
          st = (err * int'(cfg_mant)) >> (8 + int'(cfg_exp));
          if (cfg_fd_en && int'(cfg_fd_step) > st) st = int'(cfg_fd_step);
          m_gain = m_gain + st;
          if (m_gain > GMAX) m_gain = GMAX;
        end
      end
      if (fire) m_fired = 1;
      if (last) model_clear();
      else begin
        m_cnt++;
        m_peak = pk;
      end
    end
  endtask

  task automatic cyc(input bit v, input int mag);
    s_valid = v;
    s_mag   = MAG_W'(mag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, int'(gain), m_gain);
    check("R2", int'(s_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_gain = GAIN_INIT;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1", int'(gain), GAIN_INIT);
    rst_n = 1'b1;

    // R3: peaks inside the band leave gain alone
    tag = "R3";
    for (int i = 0; i < 12; i++) cyc(1, 1000 + (i * 90));
    check("R3", int'(gain), GAIN_INIT);

    // R10: idle cycles never move the gain
    tag = "R10";
    for (int i = 0; i < 6; i++) cyc(0, 4000);
    check("R10", int'(gain), GAIN_INIT);

    // R4: peak above band lowers gain; (1500*63)>>12 = 23
    tag = "R4";
    for (int i = 0; i < 4; i++) cyc(1, (i == 2) ? 3000 : 500);
    check("R4", int'(gain), GAIN_INIT - 23);

    // R5: low window raises gain; (1400*63)>>12 = 21
    tag = "R5";
    for (int i = 0; i < 4; i++) cyc(1, 100);
    check("R5", int'(gain), GAIN_INIT - 23 + 21);

    // R2: window counting across valid gaps
    tag = "R2";
    for (int i = 0; i < 16; i++) cyc(i % 3 != 0, 100);

    // R6: fast decay dominates a tiny slow step
    tag = "R6";
    cfg_mant = 6'd4; cfg_fd_en = 1'b1; cfg_force = 1'b1; cfg_force_gain = 6'd10;
    cyc(0, 0);
    cfg_force = 1'b0;
    for (int i = 0; i < 4; i++) cyc(1, 100);
    check("R6", int'(gain), 19);
    cfg_fd_en = 1'b0;

    // R7: fast attack mid-window and on the last sample; disabled has no effect
    tag = "R7";
    cfg_fa_en = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1, (i == 0 || i == 1) ? 3800 : 1500);
    check("R7", int'(gain), 14);
    for (int i = 0; i < 4; i++) cyc(1, (i >= 2) ? 3800 : 1500);
    cfg_fa_en = 1'b0;
    for (int i = 0; i < 8; i++) cyc(1, 3800);

    // R8: saturation on both ends
    tag = "R8";
    cfg_mant = 6'd63; cfg_exp = 4'd0;
    for (int i = 0; i < 8; i++) cyc(1, 0);
    check("R8", int'(gain), GMAX);
    for (int i = 0; i < 8; i++) cyc(1, 4095);
    check("R8", int'(gain), 0);

    // R9: force overrides and restarts the window
    tag = "R9";
    cfg_exp = 4'd4;
    cyc(1, 0); cyc(1, 0);
    cfg_force = 1'b1; cfg_force_gain = 6'd45;
    cyc(1, 4095); cyc(1, 4095);
    check("R9", int'(gain), 45);
    cfg_force = 1'b0;
    for (int i = 0; i < 8; i++) cyc(1, 1500);

    // Randomised mix against the reference model
    tag = "R10";
    for (int blk = 0; blk < 30; blk++) begin
      cfg_period  = 8'($urandom_range(0, 5));
      cfg_lo_thr  = MAG_W'($urandom_range(200, 1500));
      cfg_hi_thr  = MAG_W'($urandom_range(1500, 3500));
      cfg_target  = MAG_W'($urandom_range(0, 4095));
      cfg_mant    = 6'($urandom_range(0, 63));
      cfg_exp     = 4'($urandom_range(0, 6));
      cfg_fa_en   = 1'($urandom_range(0, 1));
      cfg_fa_thr  = MAG_W'($urandom_range(2000, 4000));
      cfg_fa_cnt  = 8'($urandom_range(0, 3));
      cfg_fa_step = 4'($urandom_range(0, 15));
      cfg_fd_en   = 1'($urandom_range(0, 1));
      cfg_fd_step = 4'($urandom_range(0, 15));
      for (int i = 0; i < 100; i++) begin
        cfg_force      = ($urandom_range(0, 40) == 0);
        cfg_force_gain = GAIN_W'($urandom_range(0, GMAX));
        cyc($urandom_range(0, 3) != 0, int'($urandom_range(0, 4095)));
      end
      cfg_force = 1'b0;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule